// File: doc/BRIEF.md
# Dual-Mode Pulse Rate and Event Counter

This block counts rising edges on one of eight digital inputs and presents the result to a host over an 8-bit bus with two locations, A and B. It runs in one of two modes. In frequency mode a write to location B starts a timed measurement. The counter is cleared, counts edges for a programmable gate period derived from a 1 MHz timebase enable, and the final count is latched when the gate closes. In event mode the counter runs freely. A write to location B clears it, and it wraps when it passes its maximum value.

A write to location A loads an 8-bit control byte. Bit 7 is the mode (0 = frequency, 1 = event). Bits [6:4] are the gate code. Bits [3:0] are the input selection. Codes 0–3 select channel n, counted only while channel n+4 is high. Codes 4–11 select channels 0–7 with no gating. Codes 12–15 select nothing.

A read of location A takes a snapshot of the whole count and returns its low byte. A later read of location B returns the high byte of that same snapshot, so a two-byte read is coherent even while counting continues. All inputs pass through a two-flop synchroniser. Edges are detected in the system clock domain, which must run at least four times faster than the fastest input.

Top module: `pulse_rate_counter`

## Requirements
- R1: Selection codes 4–11 count rising edges of channel (code − 4) alone; activity on the other channels has no effect on the count.
- R2: Selection codes 0–3 count rising edges of the AND of channel n and channel n+4, so edges of channel n arriving while channel n+4 is low are not counted.
- R3: Selection codes 12–15 select no input, and the count does not advance whatever the channels do.
- R4: In event mode (control bit 7 = 1), any write to location B clears the counter to zero, whatever data is written.
- R5: In event mode the counter wraps from 2^CNT_W − 1 to 0 and keeps counting.
- R6: A read of location A copies the whole count into a snapshot and returns bits [7:0] one cycle later. A read of location B returns bits [15:8] of that snapshot one cycle later, even if the live count has moved on. Counting is not disturbed by either read.
- R7: In frequency mode (control bit 7 = 0), a write to location B clears the counter and raises `busy` for exactly BASE_TICKS × 2^code timebase enable pulses, where code is control bits [6:4].
- R8: When the frequency gate closes, the count is latched. Reads then return the latched value, and edges arriving after the gate has closed do not change it.
- R9: In frequency mode the count saturates at 2^CNT_W − 1 instead of wrapping.
- R10: In event mode, control bits [6:4] are ignored: a write to location B never raises `busy`, and the count does not depend on those bits.
- R11: After reset, `bus_rdata` is 0 and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1us | input | 1 | 1 MHz timebase enable, one clock wide |
| chan_in | input | 8 | Asynchronous count inputs, channels 0–7 |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_sel | input | 1 | Location select: 0 = A, 1 = B |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered host read data |
| busy | output | 1 | High while a frequency gate is open |

## Verification
The selection logic is exercised in three ways. Random pulse trains are driven on a chosen channel while the other seven carry random noise, which separates a correct channel decode from one that leaks a neighbour. Gated pairs are driven with pulses before, during and after the gate channel is high, which tells a true AND from plain selection. An all-channel toggle pattern with an empty code shows that nothing is counted. Timing is checked separately: the gate length is measured with a randomly gapped timebase so that counting clock cycles cannot be mistaken for counting ticks. Long pulse runs past 2^CNT_W show the wrap in event mode and the saturation in frequency mode. A snapshot read that straddles a carry into the high byte shows the two-byte read is coherent.

// File: rtl/pr_pkg.sv
package pr_pkg;
  // Control byte layout: host software depends on these bit positions.
  typedef struct packed {
    logic       evt_mode;   // bit 7: 1 = event, 0 = frequency
    logic [2:0] gate_code;  // bits 6:4
    logic [3:0] in_sel;     // bits 3:0
  } ctrl_t;

  localparam int NUM_CH  = 8;
  localparam int SEL_W   = 4;
  localparam int CODE_W  = 3;
endpackage

// File: rtl/pr_input_select.sv
module pr_input_select #(
  parameter int NUM_CH = 8,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] chan_in,
  input  logic [SEL_W-1:0]  in_sel,
  output logic              cnt_edge
);
  localparam int PAIRS = NUM_CH / 2;

  logic [NUM_CH-1:0] meta_q, sync_q;
  logic [PAIRS-1:0]  paired;
  logic              sel_lvl, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= chan_in;
      sync_q <= meta_q;
    end
  end

  // Channel p counts only while its partner p+PAIRS is high.
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign paired[p] = sync_q[p] & sync_q[p+PAIRS];
  end

  always_comb begin
    sel_lvl = 1'b0;
    for (int i = 0; i < PAIRS; i++)
      if (in_sel == SEL_W'(i)) sel_lvl = paired[i];
    for (int i = 0; i < NUM_CH; i++)
      if (in_sel == SEL_W'(PAIRS + i)) sel_lvl = sync_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sel_lvl;
  end

  assign cnt_edge = sel_lvl & ~prev_q;
endmodule

// File: rtl/pr_gate_timer.sv
module pr_gate_timer #(
  parameter int BASE_TICKS = 8192,
  parameter int CODE_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              abort,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  output logic              gating,
  output logic              gate_end
);
  localparam longint MAX_TICKS = longint'(BASE_TICKS) << ((1 << CODE_W) - 1);
  localparam int     TW        = $clog2(MAX_TICKS + 1);

  logic [TW-1:0] limit_q, ticks_q;
  logic          gating_q;

  assign gate_end = gating_q & tick & (ticks_q == limit_q - TW'(1));
  assign gating   = gating_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gating_q <= 1'b0;
      ticks_q  <= '0;
      limit_q  <= '0;
    end else if (start) begin
      gating_q <= 1'b1;
      ticks_q  <= '0;
      limit_q  <= TW'(BASE_TICKS) << code;
    end else if (abort || gate_end) begin
      gating_q <= 1'b0;
    end else if (gating_q && tick) begin
      ticks_q  <= ticks_q + TW'(1);
    end
  end
endmodule

// File: rtl/pr_count_core.sv
module pr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             evt_mode,
  input  logic             gating,
  input  logic             gate_end,
  input  logic             cnt_edge,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] latch
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q, latch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (clr) begin
      count_q <= '0;
    end else if (evt_mode) begin
      if (cnt_edge) count_q <= count_q + CNT_W'(1);  // wraps
    end else if (gating && cnt_edge && !gate_end && count_q != CNT_MAX) begin
      count_q <= count_q + CNT_W'(1);                // saturates; closing cycle excluded
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 latch_q <= '0;
    else if (gate_end && !clr) latch_q <= count_q;
  end

  assign count = count_q;
  assign latch = latch_q;
endmodule

// File: rtl/pulse_rate_counter.sv
module pulse_rate_counter #(
  parameter int CNT_W      = 16,
  parameter int BASE_TICKS = 8192
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_1us,
  input  logic [7:0] chan_in,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       busy
);
  import pr_pkg::*;

  ctrl_t            ctrl_q;
  logic             wr_a, wr_b, rd_a, rd_b;
  logic             evt_mode, gating, gate_end, cnt_edge;
  logic [CNT_W-1:0] count, latch, snap_q, src;
  logic [7:0]       rdata_q;

  assign wr_a     = bus_wr & ~bus_sel;
  assign wr_b     = bus_wr &  bus_sel;
  assign rd_a     = bus_rd & ~bus_sel;
  assign rd_b     = bus_rd &  bus_sel;
  assign evt_mode = ctrl_q.evt_mode;

  always_ff @(posedge clk) begin
    if (rst)       ctrl_q <= '0;
    else if (wr_a) ctrl_q <= ctrl_t'(bus_wdata);
  end

  pr_input_select #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_sel (
    .clk      (clk),
    .rst      (rst),
    .chan_in  (chan_in),
    .in_sel   (ctrl_q.in_sel),
    .cnt_edge (cnt_edge)
  );

  // A control write that selects event mode abandons an open gate.
  pr_gate_timer #(.BASE_TICKS(BASE_TICKS), .CODE_W(CODE_W)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .start    (wr_b & ~evt_mode),
    .abort    (wr_a & bus_wdata[7]),
    .tick     (tick_1us),
    .code     (ctrl_q.gate_code),
    .gating   (gating),
    .gate_end (gate_end)
  );

  pr_count_core #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (wr_b),
    .evt_mode (evt_mode),
    .gating   (gating),
    .gate_end (gate_end),
    .cnt_edge (cnt_edge),
    .count    (count),
    .latch    (latch)
  );

  // Low-byte read snapshots the full value for a coherent high-byte read.
  assign src = evt_mode ? count : latch;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q  <= '0;
      rdata_q <= '0;
    end else if (rd_a) begin
      snap_q  <= src;
      rdata_q <= src[7:0];
    end else if (rd_b) begin
      rdata_q <= 8'(snap_q >> 8);
    end
  end

  assign bus_rdata = rdata_q;
  assign busy      = gating;
endmodule

// File: rtl/pr_checker.sv
module pr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic             bus_sel,
  input logic             busy,
  input logic             evt_mode,
  input logic [3:0]       in_sel,
  input logic             cnt_edge,
  input logic             gate_end,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] latch
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R7
  freq_start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel && !evt_mode) |=> busy);

  // R10
  evt_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel && evt_mode) |=> !busy);

  // R4
  trig_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel) |=> (count == '0));

  // R9
  freq_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (!evt_mode && count == CNT_MAX && !(bus_wr && bus_sel)) |=> (count == CNT_MAX));

  // R5
  evt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_mode && count == CNT_MAX && cnt_edge && !(bus_wr && bus_sel)) |=> (count == '0));

  // R3
  no_select_chk: assert property (@(posedge clk) disable iff (rst)
    (in_sel >= 4'd12) |-> !cnt_edge);

  // R8
  gate_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_end && !(bus_wr && bus_sel)) |=> (latch == $past(count)));
endmodule

bind pulse_rate_counter pr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_sel  (bus_sel),
  .busy     (busy),
  .evt_mode (evt_mode),
  .in_sel   (ctrl_q.in_sel),
  .cnt_edge (cnt_edge),
  .gate_end (gate_end),
  .count    (count),
  .latch    (latch)
);

// File: tb/tb_pulse_rate_counter.sv
module tb_pulse_rate_counter;
  localparam int CNT_W      = 10;
  localparam int BASE_TICKS = 64;
  localparam int CNT_MOD    = 1 << CNT_W;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1us = 1'b1;
  logic [7:0] chan_in = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       busy;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  pulse_rate_counter #(.CNT_W(CNT_W), .BASE_TICKS(BASE_TICKS)) dut (
    .clk(clk), .rst(rst), .tick_1us(tick_1us), .chan_in(chan_in),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy)
  );

  function automatic logic [7:0] ctrl_byte(bit evt, int code, int sel);
    return {evt, 3'(code), 4'(sel)};
  endfunction

  function automatic int gate_ticks(int code);
    return BASE_TICKS << code;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(bit sel, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(bit sel, output int v);
    @(negedge clk);
    bus_rd = 1'b1; bus_sel = sel;
    @(negedge clk);
    bus_rd = 1'b0;
    v = int'(bus_rdata);
  endtask

  task automatic read_count(output int v);
    int lo, hi;
    bus_read(1'b0, lo);
    bus_read(1'b1, hi);
    v = hi * 256 + lo;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // n pulses on channel ch; with noise, every other channel is randomised.
  task automatic pulse(int ch, int n, int hi_c, int lo_c, bit noise);
    for (int i = 0; i < n; i++) begin
      if (noise) chan_in = 8'($urandom);
      chan_in[ch] = 1'b1;
      repeat (hi_c) @(negedge clk);
      if (noise) chan_in = 8'($urandom);
      chan_in[ch] = 1'b0;
      repeat (lo_c) @(negedge clk);
    end
    chan_in = '0;
    idle(5);
  endtask

  task automatic setup(bit evt, int code, int sel);
    chan_in = '0;
    idle(4);
    bus_write(1'b0, ctrl_byte(evt, code, sel));
    idle(4);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int v, lo, hi, n, ch, gates;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(bus_rdata == 8'd0, "R11 rdata after reset", int'(bus_rdata), 0);
    chk(busy == 1'b0, "R11 busy after reset", int'(busy), 0);

    // R1 random ungated selection with noise on other channels
    for (int it = 0; it < 8; it++) begin
      ch = int'($urandom_range(7, 0));
      n  = int'($urandom_range(300, 0));
      setup(1'b1, int'($urandom_range(7, 0)), 4 + ch);
      bus_write(1'b1, 8'($urandom));
      pulse(ch, n, 2, 2, 1'b1);
      read_count(v);
      chk(v == n, "R1 ungated channel count", v, n);
    end

    // R2 gated pairs: pulses before, during and after the gate is high
    for (int p = 0; p < 4; p++) begin
      setup(1'b1, 0, p);
      bus_write(1'b1, 8'h00);
      pulse(p, 3, 2, 2, 1'b0);
      chan_in[p+4] = 1'b1;
      idle(3);
      pulse(p, 5 + p, 2, 2, 1'b0);
      chan_in[p+4] = 1'b1;
      idle(1);
      chan_in[p+4] = 1'b0;
      idle(3);
      pulse(p, 2, 2, 2, 1'b0);
      read_count(v);
      chk(v == 5 + p, "R2 gated pair count", v, 5 + p);
    end
    // note: pulse() clears chan_in at its end, so the gate is re-raised above
    // only briefly while channel p is low; no AND edge arises from that.

    // R3 empty selection code: every channel toggles, nothing counts
    setup(1'b1, 0, 12 + int'($urandom_range(3, 0)));
    bus_write(1'b1, 8'h5A);
    for (int i = 0; i < 20; i++) begin
      chan_in = 8'hFF; idle(2);
      chan_in = 8'h00; idle(2);
    end
    idle(4);
    read_count(v);
    chk(v == 0, "R3 no input selected", v, 0);

    // R4 clear with arbitrary data
    setup(1'b1, 0, 4 + 2);
    bus_write(1'b1, 8'h00);
    pulse(2, 37, 1, 1, 1'b0);
    bus_write(1'b1, 8'($urandom));
    read_count(v);
    chk(v == 0, "R4 event clear", v, 0);

    // R5 wrap past 2^CNT_W - 1
    bus_write(1'b1, 8'hC3);
    pulse(2, CNT_MOD + 6, 1, 1, 1'b0);
    read_count(v);
    chk(v == 6, "R5 event wrap", v, 6);

    // R6 coherent snapshot across a carry into the high byte
    setup(1'b1, 0, 4 + 5);
    bus_write(1'b1, 8'h00);
    pulse(5, 250, 1, 1, 1'b0);
    bus_read(1'b0, lo);
    chk(lo == 250, "R6 snapshot low byte", lo, 250);
    pulse(5, 10, 1, 1, 1'b0);
    bus_read(1'b1, hi);
    chk(hi == 0, "R6 high byte from snapshot", hi, 0);
    read_count(v);
    chk(v == 260, "R6 counting undisturbed by reads", v, 260);

    // R10 gate code ignored in event mode
    for (int c = 0; c < 8; c += 7) begin
      setup(1'b1, c, 4 + 1);
      bus_write(1'b1, 8'h11);
      chk(busy == 1'b0, "R10 no busy in event mode", int'(busy), 0);
      pulse(1, 9, 2, 2, 1'b1);
      read_count(v);
      chk(v == 9, "R10 count independent of gate code", v, 9);
    end

    // R7 gate length measured in randomly gapped timebase ticks
    for (int c = 0; c < 4; c++) begin
      setup(1'b0, c, 4);
      gates = 0;
      @(negedge clk);
      bus_wr = 1'b1; bus_sel = 1'b1; bus_wdata = 8'($urandom);
      tick_1us = 1'($urandom);
      @(negedge clk);
      bus_wr = 1'b0;
      for (int i = 0; i < 20000; i++) begin
        if (!busy) break;
        tick_1us = 1'($urandom);
        if (tick_1us) gates++;
        @(negedge clk);
      end
      tick_1us = 1'b1;
      chk(gates == gate_ticks(c), "R7 gate length in ticks", gates, gate_ticks(c));
    end

    // R8 frequency measurement latched at gate end
    setup(1'b0, 2, 4 + 3);
    bus_write(1'b1, 8'h00);
    chk(busy == 1'b1, "R7 busy during gate", int'(busy), 1);
    pulse(3, 40, 2, 2, 1'b1);
    wait_idle();
    read_count(v);
    chk(v == 40, "R8 latched frequency count", v, 40);
    pulse(3, 15, 2, 2, 1'b0);
    read_count(v);
    chk(v == 40, "R8 latch unchanged after gate", v, 40);

    // R9 saturation in frequency mode
    setup(1'b0, 6, 4 + 0);
    bus_write(1'b1, 8'h00);
    pulse(0, 2100, 1, 1, 1'b0);
    wait_idle();
    read_count(v);
    chk(v == CNT_MOD - 1, "R9 frequency saturation", v, CNT_MOD - 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule